// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Block

This block turns 36 input signals into 16 output data terms and 6 control terms through programmable AND and OR planes. Each data output owns five private product terms that are always ORed together. It can also draw on a pool of 32 product terms that all outputs share. A programmable OR mask for each output picks which pool terms it takes, so one pool term can drive any number of outputs at the same time. The control terms take their literals from the same inputs. Each control term can be set on its own to act as an AND of its literals or as an OR of its literals.

The configuration is held in registers. A single write port loads them one word at a time, by address, while the block is otherwise idle. Evaluation is purely combinational from the inputs and the stored configuration, with no clock cycle in the path. A 72-bit mask word describes each term. Bit i enables the true literal of input i, and bit 36+i enables the complement literal of input i.

Top module: `sop_logic_block`

## Requirements
- R1: After reset every configuration word is zero, so data_o reads 0 and ctrl_o reads all ones (6'h3f).
- R2: In a term mask, bit i (0..35) enables input i as a true literal and bit 36+i enables it as a complement literal; a product term is the AND of its enabled literals.
- R3: A product term with no literal enabled evaluates to 1; a product term that enables both literals of one input evaluates to 0.
- R4: Each data output is the OR of its five dedicated terms, each gated by its own enable bit; a disabled term contributes 0 whatever its mask.
- R5: Bits [31:0] of an output's configuration word select pool terms j (bit j); one pool term selected by several outputs drives all of them at once.
- R6: One output can combine all 37 terms (five dedicated plus 32 pool) and goes high when any single one of them is true.
- R7: Mode word bit c set to 1 makes control term c a sum (OR of its enabled literals); 0 makes it a product; each control term's mode is independent.
- R8: A sum-mode control term with no literal enabled evaluates to 0; one that enables both literals of an input evaluates to 1.
- R9: Address map: 0..79 dedicated term masks (output*5+k), 80..111 pool term masks, 112..117 control term masks, 118..133 output words (bits [31:0] pool select, bits [36:32] dedicated enables k=0..4), 134 mode word (bits [5:0]); a write replaces the addressed word on the next clock edge.
- R10: Writes to addresses 135 and above change no configuration word.
- R11: Outputs follow input changes with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for configuration writes |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the configuration |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration word address |
| cfg_data_i | input | 72 | Configuration word data |
| in_i | input | 36 | Logic inputs |
| data_o | output | 16 | Data term outputs, one per macrocell |
| ctrl_o | output | 6 | Control term outputs |

## Verification
The bench aims at the degenerate masks. An empty product must read 1 and an empty sum must read 0. A conflicting pair of literals must give 0 in product mode and 1 in sum mode. A design that swapped these identities, or that let an enable-less term through, would show a wrong output on the first vector after that configuration. It loads one output with all 37 terms and fires each term alone. A pool select that was mis-indexed or truncated would leave one of those vectors low. Pool sharing across several outputs, writes to the out-of-range addresses 135 and 200, and input changes with the clock stopped are also covered. An address decoder that aliased the high addresses would corrupt the expected outputs, and a registered output path would lag one vector behind.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int DEF_N_IN  = 36;
  localparam int DEF_N_OUT = 16;
  localparam int DEF_N_PAL = 5;
  localparam int DEF_N_PLA = 32;
  localparam int DEF_N_CT  = 6;

  typedef enum logic {
    TERM_PRODUCT = 1'b0,
    TERM_SUM     = 1'b1
  } term_mode_e;
endpackage

// File: rtl/sop_term.sv
module sop_term
  import sop_pkg::*;
#(
  parameter int N_IN = DEF_N_IN
) (
  input  logic [N_IN-1:0]   in_i,
  input  logic [2*N_IN-1:0] mask_i,
  input  term_mode_e        mode_i,
  output logic              term_o
);
  logic [N_IN-1:0] t_en, c_en;

  assign t_en = mask_i[N_IN-1:0];
  assign c_en = mask_i[2*N_IN-1:N_IN];

  always_comb begin
    if (mode_i == TERM_SUM)
      term_o = |((t_en & in_i) | (c_en & ~in_i));
    else
      term_o = &((~t_en | in_i) & (~c_en | ~in_i));
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_OUT = 16,
  parameter int N_PAL = 5,
  parameter int N_PLA = 32
) (
  input  logic [N_OUT-1:0][N_PAL-1:0] pal_term_i,
  input  logic [N_OUT-1:0][N_PAL-1:0] pal_en_i,
  input  logic [N_PLA-1:0]            pla_term_i,
  input  logic [N_OUT-1:0][N_PLA-1:0] or_mask_i,
  output logic [N_OUT-1:0]            data_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign data_o[o] = (|(pal_term_i[o] & pal_en_i[o])) | (|(pla_term_i & or_mask_i[o]));
  end
endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int N_IN  = 36,
  parameter int N_OUT = 16,
  parameter int N_PAL = 5,
  parameter int N_PLA = 32,
  parameter int N_CT  = 6,
  parameter int AW    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [2*N_IN-1:0]           data_i,
  output logic [2*N_IN-1:0]           pal_mask_o [N_OUT*N_PAL],
  output logic [2*N_IN-1:0]           pla_mask_o [N_PLA],
  output logic [2*N_IN-1:0]           ct_mask_o  [N_CT],
  output logic [N_OUT-1:0][N_PLA-1:0] or_mask_o,
  output logic [N_OUT-1:0][N_PAL-1:0] pal_en_o,
  output logic [N_CT-1:0]             ct_sum_o
);
  localparam int N_PALT    = N_OUT * N_PAL;
  localparam int PLA_BASE  = N_PALT;
  localparam int CT_BASE   = PLA_BASE + N_PLA;
  localparam int OUT_BASE  = CT_BASE + N_CT;
  localparam int MODE_ADDR = OUT_BASE + N_OUT;
  localparam int N_WORDS   = MODE_ADDR + 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_PALT; i++) pal_mask_o[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N_PALT; i++)
        if (addr_i == AW'(i)) pal_mask_o[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < N_PLA; j++) pla_mask_o[j] <= '0;
    end else if (we_i) begin
      for (int j = 0; j < N_PLA; j++)
        if (addr_i == AW'(PLA_BASE + j)) pla_mask_o[j] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CT; c++) ct_mask_o[c] <= '0;
    end else if (we_i) begin
      for (int c = 0; c < N_CT; c++)
        if (addr_i == AW'(CT_BASE + c)) ct_mask_o[c] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      or_mask_o <= '0;
      pal_en_o  <= '0;
    end else if (we_i) begin
      for (int o = 0; o < N_OUT; o++)
        if (addr_i == AW'(OUT_BASE + o)) begin
          or_mask_o[o] <= data_i[N_PLA-1:0];
          pal_en_o[o]  <= data_i[N_PLA+N_PAL-1:N_PLA];
        end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ct_sum_o <= '0;
    else if (we_i && addr_i == AW'(MODE_ADDR))  ct_sum_o <= data_i[N_CT-1:0];
  end

  a_r9_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(MODE_ADDR)) |=> ct_sum_o == $past(data_i[N_CT-1:0]));

  a_r9_out0_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(OUT_BASE)) |=>
      (or_mask_o[0] == $past(data_i[N_PLA-1:0]) && pal_en_o[0] == $past(data_i[N_PLA+N_PAL-1:N_PLA])));

  a_r10_bad_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= AW'(N_WORDS)) |=> ($stable(or_mask_o) && $stable(pal_en_o) && $stable(ct_sum_o)));

  a_r10_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(or_mask_o) && $stable(ct_sum_o)));
endmodule

// File: rtl/sop_logic_block.sv
module sop_logic_block
  import sop_pkg::*;
#(
  parameter int N_IN  = DEF_N_IN,
  parameter int N_OUT = DEF_N_OUT,
  parameter int N_PAL = DEF_N_PAL,
  parameter int N_PLA = DEF_N_PLA,
  parameter int N_CT  = DEF_N_CT,
  localparam int N_WORDS = N_OUT * N_PAL + N_PLA + N_CT + N_OUT + 1,
  localparam int AW      = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [2*N_IN-1:0] cfg_data_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_OUT-1:0]  data_o,
  output logic [N_CT-1:0]   ctrl_o
);
  localparam int N_PALT = N_OUT * N_PAL;

  logic [2*N_IN-1:0]           pal_mask [N_PALT];
  logic [2*N_IN-1:0]           pla_mask [N_PLA];
  logic [2*N_IN-1:0]           ct_mask  [N_CT];
  logic [N_OUT-1:0][N_PLA-1:0] or_mask;
  logic [N_OUT-1:0][N_PAL-1:0] pal_en;
  logic [N_CT-1:0]             ct_sum;
  logic [N_OUT-1:0][N_PAL-1:0] pal_term;
  logic [N_PLA-1:0]            pla_term;

  sop_cfg_store #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_PAL(N_PAL), .N_PLA(N_PLA), .N_CT(N_CT), .AW(AW)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .data_i     (cfg_data_i),
    .pal_mask_o (pal_mask),
    .pla_mask_o (pla_mask),
    .ct_mask_o  (ct_mask),
    .or_mask_o  (or_mask),
    .pal_en_o   (pal_en),
    .ct_sum_o   (ct_sum)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_pal_out
    for (genvar k = 0; k < N_PAL; k++) begin : g_pal_term
      sop_term #(.N_IN(N_IN)) u_term (
        .in_i   (in_i),
        .mask_i (pal_mask[o*N_PAL+k]),
        .mode_i (TERM_PRODUCT),
        .term_o (pal_term[o][k])
      );
    end
  end

  for (genvar j = 0; j < N_PLA; j++) begin : g_pla
    sop_term #(.N_IN(N_IN)) u_term (
      .in_i   (in_i),
      .mask_i (pla_mask[j]),
      .mode_i (TERM_PRODUCT),
      .term_o (pla_term[j])
    );
  end

  for (genvar c = 0; c < N_CT; c++) begin : g_ct
    sop_term #(.N_IN(N_IN)) u_term (
      .in_i   (in_i),
      .mask_i (ct_mask[c]),
      .mode_i (term_mode_e'(ct_sum[c])),
      .term_o (ctrl_o[c])
    );

    a_r3_empty_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ct_sum[c] && ct_mask[c] == '0) |-> ctrl_o[c]);

    a_r8_empty_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ct_sum[c] && ct_mask[c] == '0) |-> !ctrl_o[c]);
  end

  sop_or_plane #(.N_OUT(N_OUT), .N_PAL(N_PAL), .N_PLA(N_PLA)) u_or (
    .pal_term_i (pal_term),
    .pal_en_i   (pal_en),
    .pla_term_i (pla_term),
    .or_mask_i  (or_mask),
    .data_o     (data_o)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    a_r4_idle_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pal_en[o] == '0 && or_mask[o] == '0) |-> !data_o[o]);

    a_r5_shared_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(or_mask[o] & pla_term)) |-> data_o[o]);

    a_r4_private_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(pal_en[o] & pal_term[o])) |-> data_o[o]);
  end
endmodule

// File: tb/tb_sop_logic_block.sv
module tb_sop_logic_block;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 36, NO = 16, NP = 5, NQ = 32, NC = 6;
  localparam int PLA_B = NO * NP, CT_B = PLA_B + NQ, OUT_B = CT_B + NC, MODE_A = OUT_B + NO;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [7:0]    cfg_addr_i = '0;
  logic [71:0]   cfg_data_i = '0;
  logic [NI-1:0] in_i = '0;
  logic [NO-1:0] data_o;
  logic [NC-1:0] ctrl_o;

  sop_logic_block dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_data_i(cfg_data_i), .in_i(in_i), .data_o(data_o), .ctrl_o(ctrl_o)
  );

  bit clk_run = 1'b1;
  always begin
    #(CLK_PERIOD/2);
    if (clk_run) clk_i = ~clk_i;
  end

  // reference configuration, built from the address map
  logic [71:0] m_pal [NO*NP];
  logic [71:0] m_pla [NQ];
  logic [71:0] m_ct  [NC];
  logic [NQ-1:0] m_or [NO];
  logic [NP-1:0] m_en [NO];
  logic [NC-1:0] m_sum;

  typedef struct {
    logic [NO-1:0] d;
    logic [NC-1:0] c;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic bit ev(input logic [71:0] m, input logic [NI-1:0] x, input bit is_sum);
    bit acc;
    acc = is_sum ? 1'b0 : 1'b1;
    for (int i = 0; i < NI; i++) begin
      if (m[i]) begin
        if (is_sum) acc = acc | x[i]; else acc = acc & x[i];
      end
      if (m[NI+i]) begin
        if (is_sum) acc = acc | !x[i]; else acc = acc & !x[i];
      end
    end
    return acc;
  endfunction

  function automatic logic [71:0] lit(input int idx, input bit comp);
    logic [71:0] r;
    r = '0;
    r[comp ? NI + idx : idx] = 1'b1;
    return r;
  endfunction

  task automatic cfg_write(input int addr, input logic [71:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 8'(addr); cfg_data_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (addr < PLA_B) m_pal[addr] = data;
    else if (addr < CT_B) m_pla[addr-PLA_B] = data;
    else if (addr < OUT_B) m_ct[addr-CT_B] = data;
    else if (addr < MODE_A) begin
      m_or[addr-OUT_B] = data[NQ-1:0];
      m_en[addr-OUT_B] = data[NQ+NP-1:NQ];
    end else if (addr == MODE_A) m_sum = data[NC-1:0];
  endtask

  task automatic apply(input logic [NI-1:0] v, input string tag);
    exp_t e;
    if (clk_run) @(negedge clk_i); else #3;
    in_i = v;
    #1;
    for (int o = 0; o < NO; o++) begin
      e.d[o] = 1'b0;
      for (int k = 0; k < NP; k++) if (m_en[o][k] && ev(m_pal[o*NP+k], v, 1'b0)) e.d[o] = 1'b1;
      for (int j = 0; j < NQ; j++) if (m_or[o][j] && ev(m_pla[j], v, 1'b0)) e.d[o] = 1'b1;
    end
    for (int c = 0; c < NC; c++) e.c[c] = ev(m_ct[c], v, m_sum[c]);
    e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      checks++;
      if (data_o !== e.d || ctrl_o !== e.c) begin
        fails++;
        $display("FAIL %s: data_o=%h ctrl_o=%h expected data_o=%h ctrl_o=%h", e.tag, data_o, ctrl_o, e.d, e.c);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [71:0] w;
    for (int i = 0; i < NO*NP; i++) m_pal[i] = '0;
    for (int j = 0; j < NQ; j++) m_pla[j] = '0;
    for (int c = 0; c < NC; c++) m_ct[c] = '0;
    for (int o = 0; o < NO; o++) begin m_or[o] = '0; m_en[o] = '0; end
    m_sum = '0;

    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    apply('0, "R1 reset");
    apply({NI{1'b1}}, "R1 reset ones");

    // R2/R4: out0 term0 = in0 & !in1, enabled
    cfg_write(0 * NP + 0, lit(0, 0) | lit(1, 1));
    cfg_write(OUT_B + 0, 72'(5'b00001) << NQ);
    apply(36'h1, "R2 true and complement hit");
    apply(36'h3, "R2 complement literal blocks");
    apply(36'h0, "R2 true literal blocks");
    // R4: out0 term3 same as a live term, but not enabled
    cfg_write(0 * NP + 3, lit(5, 0));
    apply(36'h20, "R4 disabled term contributes 0");
    // R4: out1 two enabled private terms ORed
    cfg_write(1 * NP + 1, lit(6, 0));
    cfg_write(1 * NP + 4, lit(7, 0) | lit(8, 0));
    cfg_write(OUT_B + 1, 72'(5'b10010) << NQ);
    apply(36'h040, "R4 first private term");
    apply(36'h180, "R4 second private term");
    apply(36'h080, "R4 partial term stays low");

    // R3: empty enabled term, conflicting enabled term
    cfg_write(OUT_B + 2, 72'(5'b00001) << NQ);
    apply(36'h0, "R3 empty product is 1");
    cfg_write(3 * NP + 0, lit(9, 0) | lit(9, 1));
    cfg_write(OUT_B + 3, 72'(5'b00001) << NQ);
    apply(36'h200, "R3 conflicting product is 0 (in9=1)");
    apply(36'h000, "R3 conflicting product is 0 (in9=0)");

    // R5: pool term 5 shared by out4, out5, out15
    cfg_write(PLA_B + 5, lit(35, 0));
    cfg_write(OUT_B + 4, 72'(32'h20));
    cfg_write(OUT_B + 5, 72'(32'h20));
    cfg_write(OUT_B + 15, 72'(32'h20));
    apply(36'h800000000, "R5 shared pool term on three outputs");
    apply(36'h000000000, "R5 shared pool term low");

    // R6: out6 uses all 37 terms
    for (int k = 0; k < NP; k++) cfg_write(6 * NP + k, lit(k, 0));
    for (int j = 0; j < NQ - 1; j++) cfg_write(PLA_B + j, lit(5 + j, 0));
    cfg_write(PLA_B + NQ - 1, lit(0, 0) | lit(35, 0));
    w = '0; w[NQ-1:0] = '1; w[NQ+NP-1:NQ] = '1;
    cfg_write(OUT_B + 6, w);
    apply('0, "R6 all 37 terms low");
    for (int b = 0; b < NI; b++) apply(36'(1) << b, "R6 single term fires");
    apply(36'h800000001, "R6 last pool term");

    // R7/R8: control term modes
    cfg_write(CT_B + 0, lit(0, 0) | lit(1, 0));
    cfg_write(CT_B + 1, lit(0, 0) | lit(1, 0));
    cfg_write(CT_B + 3, lit(2, 0) | lit(2, 1));
    cfg_write(CT_B + 5, lit(3, 1));
    cfg_write(MODE_A, 72'(6'b101110));
    apply(36'h0, "R7 R8 modes, inputs low");
    apply(36'h1, "R7 sum vs product one literal");
    apply(36'h3, "R7 product both literals");
    apply(36'hc, "R8 conflicting sum is 1, empty sum is 0");
    cfg_write(MODE_A, 72'(6'b000001));
    apply(36'h1, "R7 ct0 now sum, ct1 now product");

    // R9: overwrite a term and an output word
    cfg_write(0, lit(10, 0));
    apply(36'h400, "R9 rewritten term");
    apply(36'h001, "R9 old literal gone");
    cfg_write(OUT_B + 4, 72'(32'h1));
    apply(36'h800000020, "R9 rewritten pool select");

    // R10: out-of-range writes
    cfg_write(MODE_A + 1, '1);
    cfg_write(200, '1);
    cfg_write(255, '1);
    apply(36'h0, "R10 bad write ignored, low");
    apply(36'h5a5a5a5a5, "R10 bad write ignored, pattern");

    // R11: clock stopped, outputs still follow inputs
    @(negedge clk_i);
    clk_run = 1'b0;
    apply(36'h001, "R11 no clock");
    apply(36'h400, "R11 no clock");
    apply(36'h800000000, "R11 no clock");
    clk_run = 1'b1;

    for (int n = 0; n < 60; n++) apply(36'({$urandom, $urandom}), "R6 R7 mixed vector");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule